// File: doc/BRIEF.md
# Channel Enable Command and Status Tracker

This block sits beside one serial channel and turns command bytes written by software into enable levels for the channel's transmitter and receiver. A command byte counts as an enable/disable command only when its upper nibble has a fixed header pattern. The low nibble then carries four request bits: enable the transmitter, disable the transmitter, enable the receiver, and disable the receiver. Only a fixed set of nibble codes is acted on.

The block also keeps a read-only status byte for the channel. It shows both enable levels and the software flow-control state that the receiver has signalled to the far end. The send-XON and send-XOFF commands reach the block as already-decoded strobes. A strobe from the receive path marks each ordinary (non-flow-control) character. The transmitter supplies its own flow state as two levels, and the block only passes those levels into the status byte. A channel reset strobe returns all of this state to zero.

Top module: `chan_ctl_top`

## Requirements
- R1: A write changes no enable state unless bits 7:5 of the byte are 0 and bit 4 is 1. Any other upper-bit pattern leaves both enables unchanged.
- R2: With a valid header, the low-nibble codes act on one side as follows: 1000 enables the transmitter, 0100 disables the transmitter, 0010 enables the receiver, and 0001 disables the receiver.
- R3: With a valid header, the low-nibble codes act on both sides as follows: 1010 enables both, 0101 disables both, 0110 disables the transmitter and enables the receiver, and 1001 enables the transmitter and disables the receiver.
- R4: Every other low-nibble code leaves both enables unchanged. This includes any code that both enables and disables the same side, and also 0000.
- R5: The status byte is ordered as follows: bit 7 receiver enabled, bit 6 receiver flow off, bit 5 receiver flow on, bit 3 transmitter enabled, bit 2 transmitter flow off, bit 1 transmitter flow on. Bits 4 and 0 read 0. The status byte is 0x00 after reset.
- R6: The receiver flow-off bit sets one cycle after a send-XOFF strobe. It clears one cycle after a send-XON strobe or after any accepted command that enables or disables the receiver.
- R7: The receiver flow-on bit sets one cycle after a send-XON strobe. It clears one cycle after an ordinary-character strobe or after any accepted command that enables or disables the receiver.
- R8: When a set event and a clear event for the same flow bit arrive in the same cycle, the bit ends up set.
- R9: A channel reset strobe clears both enables and both receiver flow bits on the next edge, and it overrides every other input in that cycle.
- R10: Status bits 2 and 1 follow the transmitter's flow-off and flow-on inputs in the same cycle.
- R11: Status bits 7 and 3 equal the receiver and transmitter enable outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_we_i | input | 1 | Command byte write strobe |
| cmd_data_i | input | 8 | Command byte |
| chan_rst_i | input | 1 | Channel reset strobe |
| send_xon_i | input | 1 | Send-XON command strobe |
| send_xoff_i | input | 1 | Send-XOFF command strobe |
| rx_plain_i | input | 1 | Ordinary received character strobe |
| tx_flow_off_i | input | 1 | Transmitter flow-off level |
| tx_flow_on_i | input | 1 | Transmitter flow-on level |
| tx_en_o | output | 1 | Transmitter enable |
| rx_en_o | output | 1 | Receiver enable |
| status_o | output | 8 | Channel status byte |

## Verification
The assertions assume that every input strobe lasts exactly one clock. They also assume that a strobe can coincide with a channel reset, and that reset then decides the outcome; each property therefore excludes cycles with a channel reset. The stimulus drives every strobe for a single cycle between falling edges. It sweeps all 256 command bytes from each of the four enable states, with the flow-on bit set beforehand so that any unintended clearing shows up. Directed cases then combine same-cycle strobes to exercise the rules on priority.

// File: rtl/chan_ctl_pkg.sv
package chan_ctl_pkg;
  localparam int unsigned CMD_W = 8;
  localparam int unsigned NIB_W = 4;
  localparam int unsigned HDR_W = CMD_W - NIB_W;
  localparam logic [HDR_W-1:0] HDR_CODE = 4'b0001;
  localparam int unsigned SIDES = 2;
  localparam int unsigned SIDE_TX = 0;
  localparam int unsigned SIDE_RX = 1;

  typedef struct packed {
    logic tx_on;
    logic tx_off;
    logic rx_on;
    logic rx_off;
  } en_cmd_t;
endpackage

// File: rtl/chan_cmd_decode.sv
module chan_cmd_decode
  import chan_ctl_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [CMD_W-1:0] data_i,
  output en_cmd_t          cmd_o
);
  logic             hdr_ok;
  logic [NIB_W-1:0] nib;
  en_cmd_t          dec;

  assign hdr_ok = (data_i[CMD_W-1:NIB_W] == HDR_CODE);
  assign nib    = data_i[NIB_W-1:0];

  always_comb begin
    dec = '0;
    unique case (nib)
      4'b0001: dec.rx_off = 1'b1;
      4'b0010: dec.rx_on  = 1'b1;
      4'b0100: dec.tx_off = 1'b1;
      4'b1000: dec.tx_on  = 1'b1;
      4'b0101: begin dec.tx_off = 1'b1; dec.rx_off = 1'b1; end
      4'b0110: begin dec.tx_off = 1'b1; dec.rx_on  = 1'b1; end
      4'b1001: begin dec.tx_on  = 1'b1; dec.rx_off = 1'b1; end
      4'b1010: begin dec.tx_on  = 1'b1; dec.rx_on  = 1'b1; end
      default: dec = '0;
    endcase
  end

  assign cmd_o = (we_i && hdr_ok) ? dec : '0;

  // a decoded command never asks one side for both states
  p_no_conflict_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cmd_o.tx_on && cmd_o.tx_off) && !(cmd_o.rx_on && cmd_o.rx_off));
endmodule

// File: rtl/chan_enable_reg.sv
module chan_enable_reg
  import chan_ctl_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             chan_rst_i,
  input  logic [SIDES-1:0] set_i,
  input  logic [SIDES-1:0] clr_i,
  output logic [SIDES-1:0] en_o
);
  for (genvar s = 0; s < SIDES; s++) begin : g_side
    logic en_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)         en_q <= 1'b0;
      else if (chan_rst_i) en_q <= 1'b0;
      else if (set_i[s])   en_q <= 1'b1;
      else if (clr_i[s])   en_q <= 1'b0;
    end
    assign en_o[s] = en_q;

    p_set_takes_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_i[s] && !chan_rst_i |=> en_o[s]);
    p_clr_takes_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      clr_i[s] && !set_i[s] && !chan_rst_i |=> !en_o[s]);
  end

  p_rst_clears_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chan_rst_i |=> en_o == '0);
endmodule

// File: rtl/chan_rx_flow.sv
module chan_rx_flow (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic chan_rst_i,
  input  logic send_xon_i,
  input  logic send_xoff_i,
  input  logic rx_touch_i,
  input  logic rx_plain_i,
  output logic flow_off_o,
  output logic flow_on_o
);
  logic off_q, on_q;

  // set wins over clear; channel reset wins over all
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         off_q <= 1'b0;
    else if (chan_rst_i)                 off_q <= 1'b0;
    else if (send_xoff_i)                off_q <= 1'b1;
    else if (send_xon_i || rx_touch_i)   off_q <= 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         on_q <= 1'b0;
    else if (chan_rst_i)                 on_q <= 1'b0;
    else if (send_xon_i)                 on_q <= 1'b1;
    else if (rx_plain_i || rx_touch_i)   on_q <= 1'b0;
  end

  assign flow_off_o = off_q;
  assign flow_on_o  = on_q;

  p_xoff_sets_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    send_xoff_i && !chan_rst_i |=> flow_off_o);
  p_off_clears_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (send_xon_i || rx_touch_i) && !send_xoff_i |=> !flow_off_o);
  p_xon_sets_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    send_xon_i && !chan_rst_i |=> flow_on_o);
  p_on_clears_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_plain_i || rx_touch_i) && !send_xon_i |=> !flow_on_o);
  p_set_wins_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    send_xon_i && send_xoff_i && !chan_rst_i |=> flow_on_o && flow_off_o);
  p_rst_flow_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chan_rst_i |=> !flow_on_o && !flow_off_o);
endmodule

// File: rtl/chan_ctl_top.sv
module chan_ctl_top
  import chan_ctl_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmd_we_i,
  input  logic [CMD_W-1:0] cmd_data_i,
  input  logic             chan_rst_i,
  input  logic             send_xon_i,
  input  logic             send_xoff_i,
  input  logic             rx_plain_i,
  input  logic             tx_flow_off_i,
  input  logic             tx_flow_on_i,
  output logic             tx_en_o,
  output logic             rx_en_o,
  output logic [CMD_W-1:0] status_o
);
  en_cmd_t          cmd;
  logic [SIDES-1:0] en_set, en_clr, en;
  logic             rx_off_q, rx_on_q;

  chan_cmd_decode u_dec (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (cmd_we_i),
    .data_i (cmd_data_i),
    .cmd_o  (cmd)
  );

  assign en_set[SIDE_TX] = cmd.tx_on;
  assign en_set[SIDE_RX] = cmd.rx_on;
  assign en_clr[SIDE_TX] = cmd.tx_off;
  assign en_clr[SIDE_RX] = cmd.rx_off;

  chan_enable_reg u_en (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .chan_rst_i (chan_rst_i),
    .set_i      (en_set),
    .clr_i      (en_clr),
    .en_o       (en)
  );

  chan_rx_flow u_flow (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .chan_rst_i  (chan_rst_i),
    .send_xon_i  (send_xon_i),
    .send_xoff_i (send_xoff_i),
    .rx_touch_i  (cmd.rx_on | cmd.rx_off),
    .rx_plain_i  (rx_plain_i),
    .flow_off_o  (rx_off_q),
    .flow_on_o   (rx_on_q)
  );

  assign tx_en_o  = en[SIDE_TX];
  assign rx_en_o  = en[SIDE_RX];
  assign status_o = {rx_en_o, rx_off_q, rx_on_q, 1'b0,
                     tx_en_o, tx_flow_off_i, tx_flow_on_i, 1'b0};

  p_bad_hdr_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_we_i && (cmd_data_i[CMD_W-1:NIB_W] != HDR_CODE) && !chan_rst_i
    |=> $stable({tx_en_o, rx_en_o}));
  p_rx_cmd_flow_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_we_i && (cmd_data_i == 8'h12) && !send_xoff_i && !send_xon_i
    |=> !status_o[6] && !status_o[5]);
endmodule

// File: tb/sim_chan_ctl_top.sv
module sim_chan_ctl_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       we = 1'b0, crst = 1'b0, xon = 1'b0, xoff = 1'b0, plain = 1'b0;
  logic       tfo = 1'b0, tfn = 1'b0;
  logic [7:0] data = 8'h00;
  logic       tx_en, rx_en;
  logic [7:0] st;
  int checks = 0, errors = 0;
  logic exp_tx, exp_rx, exp_off, exp_on;

  always #4 clk = ~clk;

  chan_ctl_top u0 (
    .clk_i(clk), .rst_ni(rst_n), .cmd_we_i(we), .cmd_data_i(data),
    .chan_rst_i(crst), .send_xon_i(xon), .send_xoff_i(xoff),
    .rx_plain_i(plain), .tx_flow_off_i(tfo), .tx_flow_on_i(tfn),
    .tx_en_o(tx_en), .rx_en_o(rx_en), .status_o(st)
  );

  function automatic logic [7:0] exp_st();
    return {exp_rx, exp_off, exp_on, 1'b0, exp_tx, tfo, tfn, 1'b0};
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%02h exp=%02h", req, act, exp);
    end
  endtask

  task automatic chk_all(input string req);
    chk(req, {6'b0, tx_en, rx_en}, {6'b0, exp_tx, exp_rx});
    chk(req, st, exp_st());
  endtask

  // one-cycle stimulus; returns at the falling edge after the capturing edge
  task automatic step(input logic w, input logic [7:0] d, input logic r,
                      input logic on, input logic off, input logic pl);
    @(negedge clk);
    we = w; data = d; crst = r; xon = on; xoff = off; plain = pl;
    @(negedge clk);
    we = 0; crst = 0; xon = 0; xoff = 0; plain = 0;
  endtask

  // expected effect of a command byte, from R1-style header rule and R2/R3 codes
  task automatic model_cmd(input logic [7:0] b);
    if (b[7:4] == 4'b0001) begin
      case (b[3:0])
        4'b0001: begin exp_rx = 0; exp_off = 0; exp_on = 0; end
        4'b0010: begin exp_rx = 1; exp_off = 0; exp_on = 0; end
        4'b0100: exp_tx = 0;
        4'b1000: exp_tx = 1;
        4'b0101: begin exp_tx = 0; exp_rx = 0; exp_off = 0; exp_on = 0; end
        4'b0110: begin exp_tx = 0; exp_rx = 1; exp_off = 0; exp_on = 0; end
        4'b1001: begin exp_tx = 1; exp_rx = 0; exp_off = 0; exp_on = 0; end
        4'b1010: begin exp_tx = 1; exp_rx = 1; exp_off = 0; exp_on = 0; end
        default: ;
      endcase
    end
  endtask

  initial begin : wd
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog act=hung exp=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    exp_tx = 0; exp_rx = 0; exp_off = 0; exp_on = 0;
    repeat (3) @(negedge clk);
    chk_all("R5 reset");
    rst_n = 1;
    @(negedge clk);
    chk_all("R5 after release");

    // R1-R4, R11: every byte from every enable state, flow-on set beforehand
    for (int s = 0; s < 4; s++) begin
      for (int b = 0; b < 256; b++) begin
        step(0, 8'h00, 1, 0, 0, 0);
        step(1, s[0] ? 8'h18 : 8'h14, 0, 0, 0, 0);
        step(1, s[1] ? 8'h12 : 8'h11, 0, 1, 0, 0);
        exp_tx = s[0]; exp_rx = s[1]; exp_off = 0; exp_on = 1;
        tfo = b[0]; tfn = b[1];
        step(1, b[7:0], 0, 0, 0, 0);
        model_cmd(b[7:0]);
        chk_all(b[7:4] != 4'b0001 ? "R1" :
                (b[3:0] inside {4'h1, 4'h2, 4'h4, 4'h8}) ? "R2" :
                (b[3:0] inside {4'h5, 4'h6, 4'h9, 4'hA}) ? "R3" : "R4");
        chk("R11", {st[7], st[3]}, {rx_en, tx_en});
      end
    end

    // R10: transmitter flow levels pass straight through
    for (int v = 0; v < 4; v++) begin
      @(negedge clk); tfo = v[0]; tfn = v[1]; #1;
      chk("R10", {6'b0, st[2], st[1]}, {6'b0, v[0], v[1]});
    end
    tfo = 0; tfn = 0;

    // R6/R7 flow sequences
    step(0, 0, 1, 0, 0, 0);
    exp_tx = 0; exp_rx = 0; exp_off = 0; exp_on = 0;
    step(0, 0, 0, 0, 1, 0); exp_off = 1; chk_all("R6 xoff sets");
    step(0, 0, 0, 1, 0, 0); exp_off = 0; exp_on = 1; chk_all("R6 R7 xon");
    step(0, 0, 0, 0, 0, 1); exp_on = 0; chk_all("R7 plain clears");
    step(0, 0, 0, 0, 1, 0); exp_off = 1; chk_all("R6 xoff again");
    step(1, 8'h11, 0, 0, 0, 0); exp_off = 0; chk_all("R6 rx disable clears");
    step(0, 0, 0, 1, 0, 0); exp_on = 1; chk_all("R7 xon");
    step(1, 8'h18, 0, 0, 0, 0); exp_tx = 1; chk_all("R7 tx cmd keeps");
    step(1, 8'h32, 0, 0, 0, 0); chk_all("R1 bad hdr keeps flow");

    // R8 same-cycle set/clear
    step(0, 0, 0, 1, 0, 1); exp_on = 1; chk_all("R8 xon+plain");
    step(0, 0, 0, 1, 1, 0); exp_on = 1; exp_off = 1; chk_all("R8 xon+xoff");
    step(1, 8'h12, 0, 0, 1, 0); exp_rx = 1; exp_on = 0; exp_off = 1;
    chk_all("R8 xoff+rx enable");

    // R9 reset overrides everything
    step(1, 8'h1A, 1, 1, 1, 0);
    exp_tx = 0; exp_rx = 0; exp_off = 0; exp_on = 0;
    chk_all("R9 reset wins");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule